// File: doc/BRIEF.md
# Window-Gated Slow-to-Fast Bus Capture

This block carries a data bus from a slow clock domain into a faster one without giving each bit its own synchronizer chain. A single short chain of flip-flops, clocked by the fast clock, samples the slow clock waveform itself. Its last stage is a delayed copy of the slow clock, the capture window. While the window is high, the slow source register has just been loaded and cannot change, so the fast-domain register may take the bus directly through a plain 2:1 selector.

Outside the window the fast-domain register either keeps its value or, when a local select is asserted, loads a word from the fast domain. The local load is how fast-domain logic clears, presets or overwrites the register. The local load wins over window capture. One chain serves the whole bus. Correct capture needs 50% duty cycles on both clocks and a slow period longer than 2·(SYNC_STAGES+1) fast periods, which is about 8:1 for the default depth of 3. The routing delay from the slow source to the capture register must stay below SYNC_STAGES fast periods.

Top module: `win_gated_capture`

## Requirements
- R1: While rst_ni is low, data_o is all zeros and every window chain stage is cleared.
- R2: When local_sel_i is low and the capture window is high at a fast rising edge, data_o takes slow_data_i at that edge.
- R3: When local_sel_i is low and the window is low, data_o holds its value. A new slow word is not visible on data_o during the first 3 fast edges after the slow rising edge that produced it (SYNC_STAGES=3).
- R4: When local_sel_i is high at a fast rising edge, data_o takes local_data_i, whatever the window state.
- R5: With local_sel_i low, every value on data_o is a value the slow source actually held, at slow-to-fast period ratios of about 31.1 and about 8.1.
- R6: With local_sel_i low, a word loaded into the slow source at a slow rising edge is on data_o after the 4th fast rising edge that follows it (SYNC_STAGES+1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast_i | input | 1 | Fast clock, clocks the chain and the capture register |
| clk_slow_i | input | 1 | Slow clock, sampled as data by the window chain |
| rst_ni | input | 1 | Active-low asynchronous reset |
| slow_data_i | input | DATA_W | Bus from the slow-domain source register |
| local_sel_i | input | 1 | Selects the fast-domain load path |
| local_data_i | input | DATA_W | Fast-domain word loaded when local_sel_i is high |
| data_o | output | DATA_W | Captured bus in the fast domain |

## Verification
On every fast cycle, the assertions check the selector's rules: load under the window, hold outside it, local priority, and that any change of data_o comes from one of the two inputs. Only the bench scenarios can show that the window really brackets stable slow data. The bench does this by driving a counting source at two clock ratios and checking that the captured values are source values. It also checks the fixed latency from a slow edge to the output and that a new word is held back while the window is still low.

// File: rtl/win_cap_pkg.sv
package win_cap_pkg;
  localparam int unsigned DEF_DATA_W      = 16;
  localparam int unsigned DEF_SYNC_STAGES = 3;

  typedef enum logic [1:0] {
    SEL_HOLD  = 2'd0,
    SEL_SLOW  = 2'd1,
    SEL_LOCAL = 2'd2
  } cap_sel_e;
endpackage

// File: rtl/win_sync_chain.sv
module win_sync_chain #(
  parameter int unsigned STAGES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slow_clk_i,
  output logic window_o
);
  logic [STAGES-1:0] stage_q;

  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stage_q[k] <= 1'b0;
          else         stage_q[k] <= slow_clk_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stage_q[k] <= 1'b0;
          else         stage_q[k] <= stage_q[k-1];
        end
      end
    end
  endgenerate

  assign window_o = stage_q[STAGES-1];

  // R1: the chain comes out of reset cleared
  a_r1_chain_clear: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (stage_q == '0));
endmodule

// File: rtl/win_cap_reg.sv
module win_cap_reg
  import win_cap_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              window_i,
  input  logic              local_sel_i,
  input  logic [DATA_W-1:0] slow_data_i,
  input  logic [DATA_W-1:0] local_data_i,
  output logic [DATA_W-1:0] data_o
);
  cap_sel_e          sel;
  logic [DATA_W-1:0] data_d, data_q;

  always_comb begin
    if (local_sel_i)   sel = SEL_LOCAL;
    else if (window_i) sel = SEL_SLOW;
    else               sel = SEL_HOLD;
  end

  always_comb begin
    unique case (sel)
      SEL_LOCAL: data_d = local_data_i;
      SEL_SLOW:  data_d = slow_data_i;
      default:   data_d = data_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_q <= '0;
    else         data_q <= data_d;
  end

  assign data_o = data_q;

  a_r2_window_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!local_sel_i && window_i) |=> (data_o == $past(slow_data_i)));

  a_r3_hold_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!local_sel_i && !window_i) |=> $stable(data_o));

  a_r4_local_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    local_sel_i |=> (data_o == $past(local_data_i)));
endmodule

// File: rtl/win_gated_capture.sv
module win_gated_capture
  import win_cap_pkg::*;
#(
  parameter int unsigned DATA_W      = DEF_DATA_W,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic              clk_fast_i,
  input  logic              clk_slow_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] slow_data_i,
  input  logic              local_sel_i,
  input  logic [DATA_W-1:0] local_data_i,
  output logic [DATA_W-1:0] data_o
);
  logic window;

  win_sync_chain #(.STAGES(SYNC_STAGES)) u_chain (
    .clk_i      (clk_fast_i),
    .rst_ni     (rst_ni),
    .slow_clk_i (clk_slow_i),
    .window_o   (window)
  );

  win_cap_reg #(.DATA_W(DATA_W)) u_cap (
    .clk_i        (clk_fast_i),
    .rst_ni       (rst_ni),
    .window_i     (window),
    .local_sel_i  (local_sel_i),
    .slow_data_i  (slow_data_i),
    .local_data_i (local_data_i),
    .data_o       (data_o)
  );

  // R5: any change on the output comes from one of the two sources
  a_r5_source_only: assert property (@(posedge clk_fast_i) disable iff (!rst_ni)
    !$stable(data_o) |-> (data_o == $past(slow_data_i) || data_o == $past(local_data_i)));
endmodule

// File: tb/win_gated_capture_test.sv
`timescale 1ns/1ps
module win_gated_capture_test;
  localparam int unsigned W = 16;

  logic         clk_fast = 1'b0;
  logic         clk_slow = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] src = 16'hfff0;
  logic [W-1:0] prev_src = 16'hfff0;
  logic         local_sel = 1'b0;
  logic [W-1:0] local_data = '0;
  logic [W-1:0] data_o;

  int   n_checks = 0, n_fail = 0;
  int   fast_since = 100;
  int   slow_count = 0;
  bit   stream_chk = 1'b0;
  bit   done = 1'b0;
  real  slow_half = 155.5;

  win_gated_capture #(.DATA_W(W), .SYNC_STAGES(3)) uut (
    .clk_fast_i   (clk_fast),
    .clk_slow_i   (clk_slow),
    .rst_ni       (rst_ni),
    .slow_data_i  (src),
    .local_sel_i  (local_sel),
    .local_data_i (local_data),
    .data_o       (data_o)
  );

  always #5 clk_fast = ~clk_fast;

  initial begin
    #100.25;
    forever begin
      clk_slow = 1'b1;
      #(slow_half);
      clk_slow = 1'b0;
      #(slow_half);
    end
  end

  always @(posedge clk_slow) begin
    prev_src   <= src;
    src        <= src + 1'b1;
    fast_since  = 0;
    slow_count  = slow_count + 1;
  end

  always @(posedge clk_fast) fast_since = fast_since + 1;

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: data_o=%h expected %h", req, act, exp);
    end
  endtask

  // R5/R6/R3 checks on the free-running stream
  always @(negedge clk_fast) begin
    if (stream_chk && slow_count > 2) begin
      if (fast_since == 3) check("R3 hold before window", data_o, prev_src);
      if (fast_since == 4) check("R6 latency", data_o, src);
      n_checks++;
      if (data_o !== src && data_o !== prev_src) begin
        n_fail++;
        $display("FAIL R5: data_o=%h expected %h or %h", data_o, src, prev_src);
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_fast);
    check("R1 reset", data_o, '0);
    n_checks++;
    if (uut.u_chain.window_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: window=%b expected 0", uut.u_chain.window_o);
    end
    repeat (30) @(negedge clk_fast);
    check("R1 reset held", data_o, '0);
    rst_ni = 1'b1;

    // ratio about 31.1
    stream_chk = 1'b1;
    repeat (60) @(posedge clk_slow);
    @(negedge clk_fast);

    // ratio about 8.1
    stream_chk = 1'b0;
    @(posedge clk_slow);
    slow_half = 40.5;
    slow_count = 0;
    @(posedge clk_slow);
    stream_chk = 1'b1;
    repeat (200) @(posedge clk_slow);
    @(negedge clk_fast);
    stream_chk = 1'b0;

    // local path: directed inside window, then random pulses
    for (int i = 0; i < 8; i++) begin
      while (fast_since != 5) @(negedge clk_fast);
      local_sel  = 1'b1;
      local_data = W'($urandom);
      @(negedge clk_fast);
      check("R4 local over open window", data_o, local_data);
      local_sel = 1'b0;
      @(negedge clk_fast);
    end
    for (int i = 0; i < 40; i++) begin
      repeat (($urandom % 5) + 1) @(negedge clk_fast);
      local_sel  = 1'b1;
      local_data = W'($urandom);
      @(negedge clk_fast);
      check("R4 local random", data_o, local_data);
      local_sel = 1'b0;
    end
    local_sel = 1'b1;
    local_data = '0;
    @(negedge clk_fast);
    check("R4 local clear", data_o, '0);
    local_sel = 1'b0;

    // back to streaming: capture resumes after the next window
    while (fast_since != 4) @(negedge clk_fast);
    check("R2 capture after local", data_o, src);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk_fast);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: done=0 expected 1");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule